// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Policy

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each evaluation takes the accumulator byte, a second operand byte, the current flag byte and a 4-bit operation code. It returns a result byte, a strobe that says whether the result should be written back, and the next flag byte. The block holds no state. Decoding, register storage and sequencing belong to the surrounding datapath.

Every operation has its own rule for each flag bit: the bit is recomputed, kept, forced to a fixed value or derived from the result. One flag bit serves two purposes. After arithmetic it holds signed overflow, and after logic operations it holds result parity.

Flag byte layout, which downstream condition logic decodes: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 are spare.

Top module: `alu8_core`

## Requirements
- R1: For every defined op code (0 to 10), flag bit 7 equals result bit 7 and flag bit 6 is set exactly when the result byte is zero.
- R2: Op 0 (add) gives A+B and op 1 (add with carry) gives A+B+flag bit 0, modulo 256, with the write strobe high. Carry (bit 0) is the carry out of bit 7. Half-carry (bit 4) is the carry out of bit 3. Bit 2 is set when the signed sum of all addends falls outside -128..127. Bit 1 is cleared.
- R3: Op 2 (subtract) gives A-B and op 3 (subtract with borrow) gives A-B-flag bit 0, modulo 256, with the write strobe high. Carry is set on a borrow out of bit 7. Half-carry is set on a borrow into bit 4. Bit 2 is set on signed overflow of the difference. Bit 1 is set.
- R4: Op 4 (compare) sets the flags exactly as op 2 would and drives result_o with A-B, but holds the write strobe low.
- R5: Op 8 (negate) gives 0-A with the write strobe high and subtraction flags. Carry is therefore set for any nonzero A, and bit 2 is set only for A = 0x80.
- R6: Op 9 (increment, A+1) and op 10 (decrement, A-1) write the result and leave flag bit 0 at its incoming value. The other arithmetic flags follow the add and subtract rules, with bit 1 cleared for increment and set for decrement.
- R7: Op 5 (AND), op 6 (OR) and op 7 (XOR) write the bitwise result. Half-carry is 1 for AND and 0 for OR and XOR. Bits 1 and 0 are cleared. Bit 2 is set when the result has an even number of one bits.
- R8: Flag bits 5 and 3 always equal the incoming flag bits 5 and 3.
- R9: Op codes 11 to 15 hold the write strobe low, return the incoming flag byte unchanged, and put the accumulator on result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Incoming flag byte |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result write strobe |
| flags_o | output | 8 | Next flag byte |

## Verification
Every defined operation is swept over all 65,536 accumulator/operand pairs, once with the incoming carry clear and once with it set. Each output is compared against integer arithmetic in the bench. The spare and non-carry flag bits are fed a pattern that changes with the operands, so a flag that should be kept but is recomputed, or the reverse, shows up as a mismatch. The signed-range overflow reference separates a true three-input overflow from an OR of partial overflows. The nibble-sum reference catches a half-carry taken from the wrong bit. A coarse sweep of the unused op codes confirms that nothing changes there.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NEG = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;

  // flag bit positions, decoded by condition logic downstream
  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_N  = 1;
  localparam int unsigned FB_PV = 2;
  localparam int unsigned FB_H  = 4;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_S  = 7;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int unsigned HB = W / 2;

  logic [W-1:0] y_eff;
  logic         cin_eff;
  logic [W:0]   full;

  // subtraction as x + ~y + ~borrow; carry flag reports borrow
  assign y_eff   = sub_i ? ~y_i : y_i;
  assign cin_eff = sub_i ^ cin_i;
  assign full    = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_eff};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W] ^ sub_i;
  assign half_o  = x_i[HB] ^ y_i[HB] ^ sum_o[HB];
  assign ovf_o   = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);

  always_comb begin
    if (sub_i && !cin_i) begin
      assert_sub_borrow_R3: assert (carry_o == (x_i < y_i));
    end
    if (!sub_i && !cin_i && (y_i == '0)) begin
      assert_add_zero_R2: assert (!carry_o && !ovf_o && (sum_o == x_i));
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         even_o
);
  import alu8_pkg::*;

  always_comb begin
    case (logic_fn_e'(fn_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

  assign even_o = ~^res_o;

  always_comb begin
    if (fn_i == LG_AND) begin
      assert_and_subset_R7: assert ((res_o & ~a_i) == '0);
    end
    if (fn_i == LG_OR) begin
      assert_or_superset_R7: assert ((a_i & ~res_o) == '0);
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic       result_we_o,
  output logic [7:0] flags_o
);
  localparam int unsigned W = DATA_W;

  logic [W-1:0] as_x, as_y, as_sum, lg_res;
  logic         as_sub, as_cin, as_c, as_h, as_v;
  logic         keep_c, is_logic, valid, lg_even;
  logic [1:0]   lg_fn;

  always_comb begin
    as_x     = acc_i;
    as_y     = opnd_i;
    as_sub   = 1'b0;
    as_cin   = 1'b0;
    keep_c   = 1'b0;
    is_logic = 1'b0;
    lg_fn    = LG_AND;
    valid    = 1'b1;
    result_we_o = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: as_cin = flags_i[FB_C];
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = flags_i[FB_C]; end
      OP_CMP: begin as_sub = 1'b1; result_we_o = 1'b0; end
      OP_NEG: begin as_x = '0; as_y = acc_i; as_sub = 1'b1; end
      OP_INC: begin as_y = W'(1); keep_c = 1'b1; end
      OP_DEC: begin as_y = W'(1); as_sub = 1'b1; keep_c = 1'b1; end
      OP_AND: is_logic = 1'b1;
      OP_OR:  begin is_logic = 1'b1; lg_fn = LG_OR; end
      OP_XOR: begin is_logic = 1'b1; lg_fn = LG_XOR; end
      default: begin valid = 1'b0; result_we_o = 1'b0; end
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .cin_i(as_cin),
    .sum_o(as_sum), .carry_o(as_c), .half_o(as_h), .ovf_o(as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .fn_i(lg_fn),
    .res_o(lg_res), .even_o(lg_even)
  );

  always_comb begin
    result_o = acc_i;
    flags_o  = flags_i;
    if (valid) begin
      result_o = is_logic ? lg_res : as_sum;
      flags_o[FB_S] = result_o[W-1];
      flags_o[FB_Z] = (result_o == '0);
      if (is_logic) begin
        flags_o[FB_H]  = (lg_fn == LG_AND);
        flags_o[FB_PV] = lg_even;
        flags_o[FB_N]  = 1'b0;
        flags_o[FB_C]  = 1'b0;
      end else begin
        flags_o[FB_H]  = as_h;
        flags_o[FB_PV] = as_v;
        flags_o[FB_N]  = as_sub;
        flags_o[FB_C]  = keep_c ? flags_i[FB_C] : as_c;
      end
    end
  end

  always_comb begin
    assert_spare_bits_R8: assert ((flags_o[5] == flags_i[5]) && (flags_o[3] == flags_i[3]));
    if (op_i == OP_CMP) begin
      assert_cmp_no_write_R4: assert (!result_we_o && flags_o[FB_N]);
    end
    if ((op_i == OP_INC) || (op_i == OP_DEC)) begin
      assert_incdec_carry_R6: assert (flags_o[FB_C] == flags_i[FB_C]);
    end
    if ((op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR)) begin
      assert_logic_clear_R7: assert (!flags_o[FB_N] && !flags_o[FB_C]);
    end
    if (op_i > 4'd10) begin
      assert_bad_op_R9: assert (!result_we_o && (flags_o == flags_i));
    end else begin
      assert_zero_flag_R1: assert (flags_o[FB_Z] == (result_o == 8'd0));
    end
  end
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] acc_i, opnd_i, flags_i, result_o, flags_o;
  logic [3:0] op_i;
  logic       result_we_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  alu8_core u_dut (
    .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i), .op_i(op_i),
    .result_o(result_o), .result_we_o(result_we_o), .flags_o(flags_o)
  );

  function automatic int sx8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {we, result, flags}
  function automatic logic [16:0] ref_model(int op, int a, int b, logic [7:0] fi);
    int x, y, ci, full, sr, r;
    bit sub, we, c, h, v, n, keepc, lg;
    logic [7:0] f;
    x = a; y = b; ci = 0; sub = 0; we = 1; keepc = 0; lg = 0; r = a;
    c = 0; h = 0; v = 0;
    f = fi;
    case (op)
      0: ;
      1: ci = fi[0];
      2: sub = 1;
      3: begin sub = 1; ci = fi[0]; end
      4: begin sub = 1; we = 0; end
      8: begin x = 0; y = a; sub = 1; end
      9: begin y = 1; keepc = 1; end
      10: begin y = 1; sub = 1; keepc = 1; end
      5: begin lg = 1; r = a & b; end
      6: begin lg = 1; r = a | b; end
      7: begin lg = 1; r = a ^ b; end
      default: return {1'b0, 8'(a), fi};
    endcase
    if (!lg) begin
      if (sub) begin
        full = x - y - ci;
        c = full < 0;
        h = ((x & 15) - (y & 15) - ci) < 0;
        sr = sx8(x) - sx8(y) - ci;
      end else begin
        full = x + y + ci;
        c = full > 255;
        h = ((x & 15) + (y & 15) + ci) > 15;
        sr = sx8(x) + sx8(y) + ci;
      end
      r = full & 255;
      v = (sr > 127) || (sr < -128);
      n = sub;
      if (keepc) c = fi[0];
      f[4] = h; f[2] = v; f[1] = n; f[0] = c;
    end else begin
      f[4] = (op == 5);
      f[2] = ($countones(8'(r)) % 2) == 0;
      f[1] = 0; f[0] = 0;
    end
    f[7] = r[7];
    f[6] = (r == 0);
    return {we, 8'(r), f};
  endfunction

  function automatic string tag_for(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      8: return "R5";
      9, 10: return "R6";
      5, 6, 7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check_vec(int op, int a, int b, logic [7:0] fi);
    logic [16:0] exp;
    logic [7:0] ef;
    op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); flags_i = fi;
    #0.5;
    exp = ref_model(op, a, b, fi);
    ef = exp[7:0];
    checks++;
    if ({result_we_o, result_o} !== exp[16:8]) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h fi=%02h: we/res=%0h expected %0h",
               tag_for(op), op, a, b, fi, {result_we_o, result_o}, exp[16:8]);
    end
    checks++;
    if (op <= 10 && flags_o[7:6] !== ef[7:6]) begin
      errors++;
      $display("FAIL R1 op=%0d a=%02h b=%02h: S,Z=%b expected %b", op, a, b, flags_o[7:6], ef[7:6]);
    end
    checks++;
    if ({flags_o[5], flags_o[3]} !== {fi[5], fi[3]}) begin
      errors++;
      $display("FAIL R8 op=%0d a=%02h b=%02h: spare=%b expected %b", op, a, b,
               {flags_o[5], flags_o[3]}, {fi[5], fi[3]});
    end
    checks++;
    if (flags_o !== ef) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h fi=%02h: flags=%02h expected %02h",
               tag_for(op), op, a, b, fi, flags_o, ef);
    end
    #0.5;
  endtask

  initial begin
    logic [7:0] fi;
    op_i = '0; acc_i = '0; opnd_i = '0; flags_i = '0;
    #2;
    for (int op = 0; op <= 10; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            fi = 8'(a * 7 + b * 13 + op * 29 + c * 101);
            fi[0] = c[0];
            check_vec(op, a, b, fi);
          end
        end
      end
    end
    // unused codes: coarse sweep (R9)
    for (int op = 11; op < 16; op++) begin
      for (int a = 0; a < 256; a += 17) begin
        for (int b = 0; b < 256; b += 17) begin
          check_vec(op, a, b, 8'(a ^ b ^ op));
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule